// File: doc/BRIEF.md
# Serial Float Word Bridge

This block is a serial-peripheral slave that sits between an external bus master and a system-clock processing pipeline. The master sends 16-bit frames on MOSI. The block joins each two consecutive frames into one 32-bit single-precision float word and emits that word as a one-cycle valid pulse with data toward a downstream write buffer. Result words go the other way. The pipeline hands the block a 32-bit result through a ready/valid input. The block returns it to the master on MISO as two 16-bit frames, which it sends during the next two frames the master clocks.

The serial logic runs on the serial clock. Chip select acts as its asynchronous clear, so a frame cut short by chip select is lost without trace. Each finished frame is announced to the system clock by flipping a toggle bit, which is synchronised and edge-detected. The master must hold chip select high for at least 12 system clocks between frames. Each readback frame uses its own chip-select assertion. A result word is accepted only while the bus is idle. The MISO pad is tri-stated through a separate output-enable port, which the top-level pad buffer uses.

Top module: `spi_word_bridge`

## Requirements
- R1: The link uses SPI mode 3. SCK idles high, MOSI is sampled on the rising SCK edge, and each frame is 16 bits sent most significant bit first.
- R2: The first frame of a pair is the upper half-word. After the second frame, `rx_word` equals {first, second} and `rx_valid` is high for one system clock.
- R3: `rx_valid` never rises after the first frame of a pair, and it never stays high for two consecutive cycles.
- R4: If chip select rises before the 16th rising edge, the partial frame is discarded. It does not count toward pairing and does not use up a readback half.
- R5: A system reset clears `rx_valid` and drops any upper half that is waiting for its partner. The next two frames after reset form a new pair.
- R6: `tx_ready` is high while no result is pending. A word is taken on a cycle where `tx_valid` and `tx_ready` are both high. `tx_ready` then stays low until both halves have been clocked out.
- R7: A taken result is sent upper half first, in the next complete frame, and lower half in the frame after. Bits are MSB first, changed on falling SCK edges and valid at rising edges.
- R8: A frame clocked while no result is pending returns all zeros on MISO.
- R9: `spi_miso_oe` is low whenever `spi_cs_n` is high and high whenever it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset, system domain |
| spi_sck | input | 1 | Serial clock from master, idles high |
| spi_cs_n | input | 1 | Active-low chip select from master |
| spi_mosi | input | 1 | Serial data from master |
| spi_miso | output | 1 | Serial data to master |
| spi_miso_oe | output | 1 | MISO pad output enable, high while selected |
| rx_valid | output | 1 | One-cycle strobe for an assembled word |
| rx_word | output | 32 | Assembled float word, upper half first received |
| tx_valid | input | 1 | Result word offered |
| tx_ready | output | 1 | Block can take a result word |
| tx_word | input | 32 | Result word to send back |

## Verification
The bench builds the bridge with its default 16-bit half-word and two-stage synchroniser. At that size a full sweep over every bit position of both directions is cheap. Eighty full-duplex word exchanges use walking-one and walking-zero words across all 32 bits, followed by hashed patterns. This exposes any swap of halves, reversed bit order or off-by-one edge in either shift path. Directed cases cover an empty readback, a frame cut short between the two halves of a pair, and a reset that lands while an upper half is waiting.

// File: rtl/sws_pkg.sv
`timescale 1ns/1ps
package sws_pkg;
  // Which half of a held result word goes out next.
  typedef enum logic {
    HALF_UPPER = 1'b0,
    HALF_LOWER = 1'b1
  } half_sel_e;
endpackage

// File: rtl/sws_sync.sv
`timescale 1ns/1ps
// Multi-stage flop synchroniser into the system clock domain.
module sws_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES] = '{default: RST_VAL};

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < int'(STAGES); i++) st[i] <= RST_VAL;
    end else begin
      st[0] <= d;
      for (int i = 1; i < int'(STAGES); i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/sws_shift_rx.sv
`timescale 1ns/1ps
// Serial-clock receive shifter: collects one frame per HALF_W rising edges.
module sws_shift_rx #(
  parameter int unsigned HALF_W = 16,
  localparam int unsigned CNT_W = $clog2(HALF_W)
) (
  input  logic              sck,
  input  logic              cs_n,
  input  logic              mosi,
  output logic [HALF_W-1:0] frame,
  output logic              frame_tgl
);
  logic [HALF_W-2:0] sh;
  logic [CNT_W-1:0]  cnt;
  logic              last;
  logic [HALF_W-1:0] frame_q = '0;
  logic              tgl_q = 1'b0;

  assign last = (cnt == CNT_W'(HALF_W - 1));

  // Chip select high clears the partial frame asynchronously.
  always_ff @(posedge sck or posedge cs_n) begin
    if (cs_n) begin
      sh  <= '0;
      cnt <= '0;
    end else begin
      sh  <= {sh[HALF_W-3:0], mosi};
      cnt <= last ? '0 : cnt + 1'b1;
    end
  end

  // Completed frame and its toggle survive chip select and reset.
  always_ff @(posedge sck) begin
    if (!cs_n && last) begin
      frame_q <= {sh, mosi};
      tgl_q   <= ~tgl_q;
    end
  end

  assign frame     = frame_q;
  assign frame_tgl = tgl_q;
endmodule

// File: rtl/sws_shift_tx.sv
`timescale 1ns/1ps
// Serial-clock transmit shifter: loads on the first falling edge of a selection.
module sws_shift_tx #(
  parameter int unsigned HALF_W = 16
) (
  input  logic              sck,
  input  logic              cs_n,
  input  logic [HALF_W-1:0] load,
  output logic              bit_out
);
  logic              started;
  logic [HALF_W-2:0] sh;

  always_ff @(negedge sck or posedge cs_n) begin
    if (cs_n) begin
      started <= 1'b0;
      sh      <= '0;
      bit_out <= 1'b0;
    end else if (!started) begin
      started <= 1'b1;
      bit_out <= load[HALF_W-1];
      sh      <= load[HALF_W-2:0];
    end else begin
      bit_out <= sh[HALF_W-2];
      sh      <= {sh[HALF_W-3:0], 1'b0};
    end
  end
endmodule

// File: rtl/sws_rx_pair.sv
`timescale 1ns/1ps
// Joins consecutive frames into one word, first frame in the upper half.
module sws_rx_pair #(
  parameter int unsigned HALF_W = 16,
  localparam int unsigned WORD_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frm_pulse,
  input  logic [HALF_W-1:0] frame,
  output logic              word_valid,
  output logic [WORD_W-1:0] word
);
  logic              have_hi;
  logic [HALF_W-1:0] upper;

  always_ff @(posedge clk) begin
    if (rst) begin
      have_hi    <= 1'b0;
      upper      <= '0;
      word_valid <= 1'b0;
      word       <= '0;
    end else begin
      word_valid <= 1'b0;
      if (frm_pulse) begin
        if (!have_hi) begin
          upper   <= frame;
          have_hi <= 1'b1;
        end else begin
          word       <= {upper, frame};
          word_valid <= 1'b1;
          have_hi    <= 1'b0;
        end
      end
    end
  end

  assert_valid_single_R3: assert property (@(posedge clk) disable iff (rst)
    word_valid |=> !word_valid);
  assert_valid_follows_frame_R2: assert property (@(posedge clk) disable iff (rst)
    word_valid |-> $past(frm_pulse));
  assert_reset_clears_R5: assert property (@(posedge clk)
    rst |=> !word_valid);
endmodule

// File: rtl/sws_tx_split.sv
`timescale 1ns/1ps
// Holds one result word and offers its halves, upper first, to the shifter.
module sws_tx_split
  import sws_pkg::*;
#(
  parameter int unsigned HALF_W = 16,
  localparam int unsigned WORD_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              word_valid,
  input  logic [WORD_W-1:0] word,
  output logic              word_ready,
  input  logic              frm_pulse,
  input  logic              bus_idle,
  output logic [HALF_W-1:0] frame_out
);
  logic              have;
  logic              shown;
  half_sel_e         half;
  logic [WORD_W-1:0] hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      have      <= 1'b0;
      shown     <= 1'b0;
      half      <= HALF_UPPER;
      hold      <= '0;
      frame_out <= '0;
    end else begin
      if (frm_pulse && shown) begin
        shown <= 1'b0;
        if (half == HALF_UPPER) begin
          half <= HALF_LOWER;
        end else begin
          half <= HALF_UPPER;
          have <= 1'b0;
        end
      end else if (bus_idle) begin
        shown <= have;
        if (!have)                   frame_out <= '0;
        else if (half == HALF_UPPER) frame_out <= hold[WORD_W-1 -: HALF_W];
        else                         frame_out <= hold[HALF_W-1:0];
      end
      if (word_valid && !have && bus_idle) begin
        have <= 1'b1;
        hold <= word;
        half <= HALF_UPPER;
      end
    end
  end

  assign word_ready = !have && bus_idle;

  assert_accept_closes_R6: assert property (@(posedge clk) disable iff (rst)
    (word_valid && word_ready) |=> !word_ready);
  assert_free_after_frame_R6: assert property (@(posedge clk) disable iff (rst)
    ($rose(word_ready) && !$past(rst) && $past(bus_idle)) |-> $past(frm_pulse));
endmodule

// File: rtl/spi_word_bridge.sv
`timescale 1ns/1ps
// Serial slave joining 16-bit frames into 32-bit float words and splitting results back.
module spi_word_bridge #(
  parameter int unsigned HALF_W = 16,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned WORD_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_sck,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              spi_miso_oe,
  output logic              rx_valid,
  output logic [WORD_W-1:0] rx_word,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [WORD_W-1:0] tx_word
);
  logic [HALF_W-1:0] rx_frame;
  logic              rx_tgl;
  logic              tgl_s;
  logic              tgl_d = 1'b0;
  logic              frm_pulse;
  logic              cs_s;
  logic [HALF_W-1:0] tx_frame;
  logic              tx_bit;

  sws_shift_rx #(.HALF_W(HALF_W)) u_rx (
    .sck(spi_sck), .cs_n(spi_cs_n), .mosi(spi_mosi),
    .frame(rx_frame), .frame_tgl(rx_tgl)
  );

  // Toggle path keeps its state across reset so no false edge appears.
  sws_sync #(.STAGES(SYNC_STAGES), .W(1), .RST_VAL(1'b0)) u_tgl_sync (
    .clk(clk), .rst(1'b0), .d(rx_tgl), .q(tgl_s)
  );

  always_ff @(posedge clk) tgl_d <= tgl_s;
  assign frm_pulse = tgl_s ^ tgl_d;

  sws_sync #(.STAGES(SYNC_STAGES), .W(1), .RST_VAL(1'b1)) u_cs_sync (
    .clk(clk), .rst(rst), .d(spi_cs_n), .q(cs_s)
  );

  sws_rx_pair #(.HALF_W(HALF_W)) u_pair (
    .clk(clk), .rst(rst), .frm_pulse(frm_pulse), .frame(rx_frame),
    .word_valid(rx_valid), .word(rx_word)
  );

  sws_tx_split #(.HALF_W(HALF_W)) u_split (
    .clk(clk), .rst(rst), .word_valid(tx_valid), .word(tx_word),
    .word_ready(tx_ready), .frm_pulse(frm_pulse), .bus_idle(cs_s),
    .frame_out(tx_frame)
  );

  sws_shift_tx #(.HALF_W(HALF_W)) u_tx (
    .sck(spi_sck), .cs_n(spi_cs_n), .load(tx_frame), .bit_out(tx_bit)
  );

  assign spi_miso    = spi_cs_n ? 1'b0 : tx_bit;
  assign spi_miso_oe = !spi_cs_n;

  assert_pulse_spaced_R3: assert property (@(posedge clk) disable iff (rst)
    frm_pulse |=> !frm_pulse);
  assert_oe_follows_cs_R9: assert property (@(posedge clk)
    spi_cs_n |-> !spi_miso_oe);
endmodule

// File: tb/spi_word_bridge_tb.sv
`timescale 1ns/1ps
module spi_word_bridge_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sck = 1'b1;
  logic        cs_n = 1'b1;
  logic        mosi = 1'b0;
  logic        tx_valid = 1'b0;
  logic [31:0] tx_word = '0;
  logic        miso, miso_oe, rx_valid, tx_ready;
  logic [31:0] rx_word;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;
  logic [31:0] got_q[$];

  always #10 clk = ~clk;

  spi_word_bridge u_dut (
    .clk(clk), .rst(rst), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_miso(miso), .spi_miso_oe(miso_oe), .rx_valid(rx_valid),
    .rx_word(rx_word), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_word(tx_word)
  );

  always @(negedge clk) if (!rst && rx_valid) got_q.push_back(rx_word);

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pattern(input int k);
    if (k < 32)      return 32'h1 << k;
    else if (k < 64) return ~(32'h1 << (k - 32));
    else             return (32'(k) * 32'h9E3779B9) ^ 32'h3F800000;
  endfunction

  // Mode 3 master: MOSI changes after the falling edge, MISO read before the rising edge.
  task automatic xfer(input logic [15:0] dout, input int nbits,
                      output logic [15:0] din, output bit oe_ok);
    din = '0;
    oe_ok = 1'b1;
    cs_n = 1'b0;
    #40;
    for (int b = 0; b < nbits; b++) begin
      sck = 1'b0;
      mosi = dout[15-b];
      #60;
      din = {din[14:0], miso};
      if (!miso_oe) oe_ok = 1'b0;
      sck = 1'b1;
      #60;
    end
    #40;
    cs_n = 1'b1;
    mosi = 1'b0;
    #400;
  endtask

  task automatic push(input logic [31:0] w);
    @(negedge clk);
    tx_valid = 1'b1;
    tx_word = w;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic expect_word(input logic [31:0] exp, input string req);
    check(got_q.size() == 1, req, 32'(got_q.size()), 32'd1);
    if (got_q.size() > 0) check(got_q[0] == exp, req, got_q[0], exp);
    got_q.delete();
  endtask

  initial begin
    logic [15:0] d0, d1;
    bit oe0, oe1;
    logic [31:0] rw, tw;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(rx_valid == 1'b0, "R5 reset valid", 32'(rx_valid), 32'd0);
    check(tx_ready == 1'b1, "R6 reset ready", 32'(tx_ready), 32'd1);
    check(miso_oe == 1'b0, "R9 idle oe", 32'(miso_oe), 32'd0);

    // Empty readback pair returns zeros.
    xfer(16'hA5C3, 16, d0, oe0);
    check(d0 == 16'h0, "R8 empty first", 32'(d0), 32'd0);
    check(got_q.size() == 0, "R3 no word after one frame", 32'(got_q.size()), 32'd0);
    xfer(16'h3C5A, 16, d1, oe1);
    check(d1 == 16'h0, "R8 empty second", 32'(d1), 32'd0);
    check(oe0 && oe1, "R9 oe during frame", 32'(oe0 && oe1), 32'd1);
    check(miso_oe == 1'b0, "R9 gap oe", 32'(miso_oe), 32'd0);
    expect_word(32'hA5C33C5A, "R2 empty pair word");

    // Full-duplex sweep over walking bits and hashed patterns.
    for (int k = 0; k < 80; k++) begin
      rw = pattern(k);
      tw = pattern((k + 5) % 80);
      push(tw);
      check(tx_ready == 1'b0, "R6 ready drops", 32'(tx_ready), 32'd0);
      xfer(rw[31:16], 16, d0, oe0);
      check(d0 == tw[31:16], "R7 upper half", 32'(d0), 32'(tw[31:16]));
      check(tx_ready == 1'b0, "R6 ready held", 32'(tx_ready), 32'd0);
      check(got_q.size() == 0, "R3 half only", 32'(got_q.size()), 32'd0);
      xfer(rw[15:0], 16, d1, oe1);
      check(d1 == tw[15:0], "R7 lower half", 32'(d1), 32'(tw[15:0]));
      check(tx_ready == 1'b1, "R6 ready back", 32'(tx_ready), 32'd1);
      expect_word(rw, "R1 R2 sweep word");
    end

    // Partial frame between the halves is discarded on both paths.
    push(32'hC0FFEE11);
    xfer(16'h1234, 16, d0, oe0);
    xfer(16'hFFFF, 7, d1, oe1);
    check(got_q.size() == 0, "R4 partial no word", 32'(got_q.size()), 32'd0);
    xfer(16'h5678, 16, d1, oe1);
    check(d0 == 16'hC0FF, "R4 upper before partial", 32'(d0), 32'h0000C0FF);
    check(d1 == 16'hEE11, "R4 lower after partial", 32'(d1), 32'h0000EE11);
    expect_word(32'h12345678, "R4 pair across partial");

    // Reset while an upper half waits drops it.
    xfer(16'hDEAD, 16, d0, oe0);
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(rx_valid == 1'b0, "R5 valid after reset", 32'(rx_valid), 32'd0);
    xfer(16'hBEEF, 16, d0, oe0);
    check(got_q.size() == 0, "R5 new pair first", 32'(got_q.size()), 32'd0);
    xfer(16'h4049, 16, d1, oe1);
    expect_word(32'hBEEF4049, "R5 fresh pair");
    check(d1 == 16'h0, "R8 zeros after reset", 32'(d1), 32'd0);

    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #3_000_000;
    if (!finished) begin
      finished = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule